// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 interrupt request lines and drives one IRQ line to a processor. Software can place any source into one of 16 vectored slots. Each slot holds a source number, an enable flag and a handler address. The lowest-numbered slot has the highest priority. A source that no enabled slot claims is still serviced, but as a non-vectored interrupt. Non-vectored interrupts rank below every vectored slot.

The processor reads the vector register to get the handler address of the winning slot. If no vectored slot can win, the read returns a programmable default address. A vectored read also marks the winning slot as in service. From then on, only slots with a lower index can interrupt, until software writes any value to the vector register. That write ends service of the highest-priority slot that is in service, so nested interrupts unwind in order.

The register port uses word addresses. A write takes effect at the clock edge. Read data is combinational from the address.

Top module: `ivc_ctrl`

## Requirements
- R1: After reset, all enables, slot registers, the default address and the in-service state are zero, `irq_o` is low, and every register reads back zero.
- R2: At word address 0x02, writing a one to bit n enables source n. At 0x03, writing a one to bit n disables source n. Zero bits leave the enables unchanged. Reading 0x02 returns the enable vector.
- R3: Address 0x00 reads the raw request lines. Address 0x01 reads the requests that are both raised and enabled.
- R4: While no slot is in service, `irq_o` equals the OR of all enabled, raised sources. This includes sources that no slot claims.
- R5: Slot k has a control register at 0x10+k, with the source number in bits 4:0 and the enable flag in bit 5, and an address register at 0x20+k. Only bits 5:0 of the control register are stored.
- R6: A read of the vector register (0x04) returns the address register of the lowest-index enabled slot whose source is raised and enabled. A vectored winner takes precedence over any non-vectored source.
- R7: When no vectored slot can win, a read of 0x04 returns the default-address register (0x05). That read puts nothing in service, so a pending non-vectored source keeps `irq_o` high.
- R8: A vector read that returns a slot's address puts that slot in service. While any slot is in service, only slots with a lower index may raise `irq_o` or win a vector read. Equal-index, higher-index and non-vectored sources are masked.
- R9: Any write to 0x04 ends service of the lowest-index slot that is in service. With nothing in service, the write has no effect.
- R10: A slot whose control bit 5 is clear never wins, even when its source is raised and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt request lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only on 0x04) |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Every source is routed in turn through a slot, and every ordered pair of slots is made to compete. A wrong priority encoder would return the address of the wrong slot. The nesting case puts a middle slot in service, then raises a lower-index source, a higher-index source and an unclaimed source. A controller that masks by the wrong comparison would either miss the nested request or let a masked source assert `irq_o`. A controller that pops the wrong in-service entry on acknowledge would stay masked after the final write. The bench also covers disabled slots and unclaimed sources. A design that ignores the slot enable flag, or that puts a default-address read into service, would return a slot address or drop `irq_o`.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   // Register word addresses
   localparam int unsigned REG_RAW    = 'h00;
   localparam int unsigned REG_STAT   = 'h01;
   localparam int unsigned REG_ENSET  = 'h02;
   localparam int unsigned REG_ENCLR  = 'h03;
   localparam int unsigned REG_VEC    = 'h04;
   localparam int unsigned REG_DFLT   = 'h05;
   localparam int unsigned CTL_BASE   = 'h10;
   localparam int unsigned VADR_BASE  = 'h20;
   localparam int unsigned MAX_SLOTS  = 16;
endpackage

// File: rtl/ivc_slot.sv
module ivc_slot #(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   localparam int SRC_W = $clog2(N_SRC),
   localparam int CTL_W = SRC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              adr_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_SRC-1:0]  status_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [DATA_W-1:0] vadr_o,
   output logic              hit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_o  <= '0;
         vadr_o <= '0;
      end else begin
         if (ctl_we) ctl_o  <= wdata[CTL_W-1:0];
         if (adr_we) vadr_o <= wdata;
      end
   end

   assign hit_o = ctl_o[SRC_W] & status_i[ctl_o[SRC_W-1:0]];
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
   parameter int N = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  hit_i,
   input  logic [N-1:0]  insvc_i,
   output logic          win_vld_o,
   output logic [IW-1:0] win_idx_o,
   output logic [N-1:0]  retire_o
);
   always_comb begin
      logic blocked;
      logic found;
      blocked   = 1'b0;
      found     = 1'b0;
      win_idx_o = '0;
      retire_o  = '0;
      for (int i = 0; i < N; i++) begin
         if (insvc_i[i] && !blocked) retire_o[i] = 1'b1;
         if (insvc_i[i]) blocked = 1'b1;
         if (!blocked && !found && hit_i[i]) begin
            found     = 1'b1;
            win_idx_o = IW'(i);
         end
      end
      win_vld_o = found;
   end
endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl #(
   parameter int N_SRC  = 32,
   parameter int N_SLOT = 16,
   parameter int DATA_W = 32,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_o
);
   import ivc_pkg::*;

   localparam int SRC_W  = $clog2(N_SRC);
   localparam int CTL_W  = SRC_W + 1;
   localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

   generate
      if (N_SLOT > int'(MAX_SLOTS) || N_SLOT < 1)
         $error("ivc_ctrl: N_SLOT out of range");
      if (N_SRC != (1 << SRC_W) || N_SRC > DATA_W)
         $error("ivc_ctrl: N_SRC must be a power of two no wider than DATA_W");
      if (AW < 6)
         $error("ivc_ctrl: AW too small for register map");
   endgenerate

   logic [N_SRC-1:0]  enable;
   logic [N_SRC-1:0]  status;
   logic [N_SLOT-1:0] insvc;
   logic [DATA_W-1:0] dflt_adr;
   logic [N_SLOT-1:0] hit;
   logic [N_SLOT-1:0] retire;
   logic              win_vld;
   logic [SLOT_W-1:0] win_idx;
   logic [CTL_W-1:0]  slot_ctl  [N_SLOT];
   logic [DATA_W-1:0] slot_vadr [N_SLOT];

   assign status = src_i & enable;

   genvar k;
   generate
      for (k = 0; k < N_SLOT; k++) begin : g_slot
         ivc_slot #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (wr_en && addr == AW'(CTL_BASE + k)),
            .adr_we   (wr_en && addr == AW'(VADR_BASE + k)),
            .wdata    (wdata),
            .status_i (status),
            .ctl_o    (slot_ctl[k]),
            .vadr_o   (slot_vadr[k]),
            .hit_o    (hit[k])
         );
      end
   endgenerate

   ivc_pick #(.N(N_SLOT)) u_pick (
      .hit_i     (hit),
      .insvc_i   (insvc),
      .win_vld_o (win_vld),
      .win_idx_o (win_idx),
      .retire_o  (retire)
   );

   wire vec_sel = (addr == AW'(REG_VEC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= '0;
         dflt_adr <= '0;
         insvc    <= '0;
      end else begin
         if (wr_en && addr == AW'(REG_ENSET)) enable <= enable | wdata[N_SRC-1:0];
         if (wr_en && addr == AW'(REG_ENCLR)) enable <= enable & ~wdata[N_SRC-1:0];
         if (wr_en && addr == AW'(REG_DFLT))  dflt_adr <= wdata;
         if (wr_en && vec_sel)
            insvc <= insvc & ~retire;
         else if (rd_en && vec_sel && win_vld)
            insvc <= insvc | (N_SLOT'(1) << win_idx);
      end
   end

   assign irq_o = win_vld | ((insvc == '0) & (|status));

   logic [3:0] sub;
   assign sub = addr[3:0];

   always_comb begin
      rdata = '0;
      if (addr == AW'(REG_RAW))        rdata = DATA_W'(src_i);
      else if (addr == AW'(REG_STAT))  rdata = DATA_W'(status);
      else if (addr == AW'(REG_ENSET)) rdata = DATA_W'(enable);
      else if (vec_sel)                rdata = win_vld ? slot_vadr[win_idx] : dflt_adr;
      else if (addr == AW'(REG_DFLT))  rdata = dflt_adr;
      else if (addr[AW-1:4] == (AW-4)'(CTL_BASE >> 4) && 32'(sub) < N_SLOT)
         rdata = DATA_W'(slot_ctl[sub[SLOT_W-1:0]]);
      else if (addr[AW-1:4] == (AW-4)'(VADR_BASE >> 4) && 32'(sub) < N_SLOT)
         rdata = slot_vadr[sub[SLOT_W-1:0]];
   end
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
   parameter int N_SRC  = 32,
   parameter int N_SLOT = 16,
   parameter int DATA_W = 32,
   parameter int AW     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [AW-1:0]     addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              irq_o,
   input logic [N_SRC-1:0]  enable,
   input logic [N_SRC-1:0]  status,
   input logic [N_SLOT-1:0] insvc,
   input logic              win_vld,
   input logic [DATA_W-1:0] dflt_adr
);
   import ivc_pkg::*;

   AST_ENSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(REG_ENSET) |=> (enable & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])); // R2
   AST_ENCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(REG_ENCLR) |=> (enable & $past(wdata[N_SRC-1:0])) == '0); // R2
   AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|status)); // R4
   AST_IDLE_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
      insvc == '0 |-> irq_o == (|status)); // R4
   AST_DEFAULT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == AW'(REG_VEC) && !win_vld |-> rdata == dflt_adr); // R7
   AST_SVC_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && addr == AW'(REG_VEC) && win_vld |=> $countones(insvc) == $past($countones(insvc)) + 1); // R8
   AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      insvc != '0 && !win_vld |-> !irq_o); // R8
   AST_SVC_POP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(REG_VEC) && insvc != '0 |=> $countones(insvc) == $past($countones(insvc)) - 1); // R9
endmodule

bind ivc_ctrl ivc_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DATA_W(DATA_W), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .irq_o(irq_o), .enable(enable), .status(status), .insvc(insvc),
   .win_vld(win_vld), .dflt_adr(dflt_adr)
);

// File: tb/sim_ivc_ctrl.sv
module sim_ivc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;
   int          nvec = 0;
   int          nfail = 0;
   logic [31:0] d;
   logic [31:0] exp_en;

   always #2 clk = ~clk;

   ivc_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] v);
      addr = a; wdata = v; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic set_src(input logic [31:0] v);
      src_i = v;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      for (int a = 0; a < 6; a++) begin
         rd(6'(a), d); chk("R1 reg", d, 32'd0);
      end
      for (int k = 0; k < 16; k++) begin
         rd(6'(16 + k), d); chk("R1 ctl", d, 32'd0);
         rd(6'(32 + k), d); chk("R1 vadr", d, 32'd0);
      end

      // R2 enable set / clear sweep
      exp_en = '0;
      for (int n = 0; n < 32; n++) begin
         wr(6'h02, 32'd1 << n); exp_en |= 32'd1 << n;
         rd(6'h02, d); chk("R2 set", d, exp_en);
      end
      wr(6'h02, 32'd0); rd(6'h02, d); chk("R2 zero set", d, 32'hFFFF_FFFF);
      wr(6'h03, 32'hAAAA_AAAA); rd(6'h02, d); chk("R2 clr", d, 32'h5555_5555);
      wr(6'h03, 32'd0); rd(6'h02, d); chk("R2 zero clr", d, 32'h5555_5555);

      // R3 / R4 raw, status and idle irq
      for (int p = 0; p < 8; p++) begin
         logic [31:0] pat;
         pat = 32'h0000_0001 << (p * 4) | (32'h1 << (31 - p * 3));
         set_src(pat);
         rd(6'h00, d); chk("R3 raw", d, pat);
         rd(6'h01, d); chk("R3 status", d, pat & 32'h5555_5555);
         chk("R4 irq", {31'd0, irq_o}, {31'd0, |(pat & 32'h5555_5555)});
      end
      set_src(32'h0);

      // R5 slot register readback
      for (int k = 0; k < 16; k++) begin
         wr(6'(16 + k), 32'hFFFF_FFC0 | 32'((k * 7 + 3) & 63));
         wr(6'(32 + k), 32'hA5A5_0000 + 32'(k));
      end
      for (int k = 0; k < 16; k++) begin
         rd(6'(16 + k), d); chk("R5 ctl", d, 32'((k * 7 + 3) & 63));
         rd(6'(32 + k), d); chk("R5 vadr", d, 32'hA5A5_0000 + 32'(k));
         wr(6'(16 + k), 32'd0);
      end

      wr(6'h02, 32'hFFFF_FFFF);
      wr(6'h05, 32'hDEAD_0000);
      rd(6'h05, d); chk("R7 dflt reg", d, 32'hDEAD_0000);

      // R6 / R8 / R9 every source through a slot
      for (int n = 0; n < 32; n++) begin
         int k;
         k = n % 16;
         wr(6'(16 + k), 32'h20 | 32'(n));
         wr(6'(32 + k), 32'h1000 + 32'(n));
         set_src(32'd1 << n);
         chk("R4 irq before", {31'd0, irq_o}, 32'd1);
         rd(6'h04, d); chk("R6 vector", d, 32'h1000 + 32'(n));
         chk("R8 self mask", {31'd0, irq_o}, 32'd0);
         wr(6'h04, 32'h0);
         chk("R9 ack", {31'd0, irq_o}, 32'd1);
         set_src(32'h0);
         wr(6'(16 + k), 32'd0);
      end

      // R7 default for unclaimed source, no service entry
      set_src(32'd1 << 20);
      rd(6'h04, d); chk("R7 default", d, 32'hDEAD_0000);
      chk("R7 irq kept", {31'd0, irq_o}, 32'd1);
      wr(6'h04, 32'h0);
      chk("R9 empty ack", {31'd0, irq_o}, 32'd1);

      // R10 disabled slot ignored
      wr(6'h12, 32'd20);
      wr(6'h22, 32'h7777);
      rd(6'h04, d); chk("R10 disabled slot", d, 32'hDEAD_0000);
      wr(6'h12, 32'd0);
      set_src(32'h0);

      // R6 every pair of slots, with an unclaimed source also pending
      for (int a = 0; a < 16; a++) begin
         for (int b = a + 1; b < 16; b++) begin
            wr(6'(16 + a), 32'h20 | 32'(a)); wr(6'(32 + a), 32'h200 + 32'(a));
            wr(6'(16 + b), 32'h20 | 32'(b)); wr(6'(32 + b), 32'h200 + 32'(b));
            set_src((32'd1 << a) | (32'd1 << b) | 32'h8000_0000);
            rd(6'h04, d); chk("R6 pair", d, 32'h200 + 32'(a));
            wr(6'h04, 32'h0);
            set_src(32'h0);
            wr(6'(16 + a), 32'd0); wr(6'(16 + b), 32'd0);
         end
      end

      // R8 / R9 nesting
      for (int k = 0; k < 16; k++) begin
         wr(6'(16 + k), 32'h20 | 32'(k)); wr(6'(32 + k), 32'h300 + 32'(k));
      end
      set_src(32'd1 << 8);
      rd(6'h04, d); chk("R8 first", d, 32'h308);
      set_src(src_i | (32'd1 << 12));
      chk("R8 lower prio masked", {31'd0, irq_o}, 32'd0);
      rd(6'h04, d); chk("R8 masked read", d, 32'hDEAD_0000);
      set_src(src_i | (32'd1 << 20));
      chk("R8 nonvec masked", {31'd0, irq_o}, 32'd0);
      set_src(src_i | (32'd1 << 3));
      chk("R8 nested irq", {31'd0, irq_o}, 32'd1);
      rd(6'h04, d); chk("R8 nested vector", d, 32'h303);
      chk("R8 nested mask", {31'd0, irq_o}, 32'd0);
      set_src(src_i & ~(32'd1 << 3));
      wr(6'h04, 32'h0);
      chk("R9 pop inner", {31'd0, irq_o}, 32'd0);
      wr(6'h04, 32'h0);
      chk("R9 pop outer", {31'd0, irq_o}, 32'd1);
      rd(6'h04, d); chk("R9 resumed", d, 32'h308);
      wr(6'h04, 32'h0);
      set_src(32'h0);
      chk("R4 idle", {31'd0, irq_o}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule